// File: doc/BRIEF.md
# Clock Request to PLL Word Encoder

This block turns a requested core clock frequency, given in whole MHz, into a packed 32-bit PLL setup word for a synthesizer fed by a 12 MHz reference. A caller places a frequency on `freq_i` and pulses `start_i`. The block then searches the input pre-divider values one per clock cycle. Among the divider values that keep the feedback count within its limit, it keeps the one whose product with the request leaves the smallest remainder modulo the reference. From that divider it derives the feedback count and the frequency actually reached. It reports a two-bit band code for the reached frequency and packs everything, with fixed constants, into the output word.

A request below 800 MHz or above 1999 MHz is refused. The refusal is reported one cycle later through `done_o` together with `err_o`, and the previous word stays on `cfg_o`. While a conversion runs, `busy_o` is high and further start pulses are dropped.

Top module: `fpll_encoder`

## Requirements
- R1: After reset `done_o`, `err_o` and `busy_o` are low and `cfg_o` is all zeros.
- R2: A start with a frequency below 800 or above 1999 gives `done_o` and `err_o` high in the next cycle, and `cfg_o` keeps its previous value. The boundary values 800 and 1999 are accepted.
- R3: The pre-divider dm is chosen by trying dm = 1, 2, ... up to 8. The search stops before any dm for which freq*dm > 3072. A trial whose remainder (freq*dm mod 12) is less than or equal to the best so far replaces it; the best starts at 12 with dm = 1. The search ends right after a trial with remainder zero. dm-1 is placed in `cfg_o[11:8]`.
- R4: The feedback count is dn = floor(freq*dm/12), and dn-1 is placed in `cfg_o[7:0]`.
- R5: The reached frequency is ach = floor(dn*12/dm). `cfg_o[17:16]` holds floor((ach-800)/300).
- R6: The fixed fields are set as follows. `cfg_o[15:12]` is 0 (post-divider 0, bit 15 spare). `cfg_o[18]` (bypass) is 0 and `cfg_o[19]` is 0. `cfg_o[20]` (halve) is 0. `cfg_o[23:21]` (system divider) is 1. `cfg_o[31:24]` is 0.
- R7: `done_o` is high for exactly one cycle per request. `busy_o` is high from the cycle after an accepted start until the cycle before `done_o`. `done_o` arrives at most 10 cycles after the start.
- R8: A start pulse while `busy_o` is high is ignored. Only the running request produces a result.
- R9: `err_o` stays high after a refusal until the next accepted request, and it is low when that request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse |
| freq_i | input | 11 | Requested frequency in MHz |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request was refused |
| cfg_o | output | 32 | Packed PLL setup word |

## Verification
The assertions assume that `freq_i` is steady in the cycle where `start_i` is sampled. They also assume that a start is only acted on when `busy_o` is low. They take for granted that, inside the accepted range, the reached frequency never drops below 800, so the band code needs no clamp. The stimulus drives each request for exactly one cycle from the falling edge. It drives extra starts on purpose only while `busy_o` is high, and it uses only frequencies whose result the bench model derives from the stated rules.

// File: rtl/fpll_pkg.sv
package fpll_pkg;

    typedef struct packed {
        logic [7:0] rsv;
        logic [2:0] sysdiv;
        logic       halve;
        logic       gap19;
        logic       bypass;
        logic [1:0] band;
        logic       gap15;
        logic [2:0] postdiv;
        logic [3:0] predm;
        logic [7:0] fbdn;
    } pll_word_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SCAN = 2'd1,
        S_MUL  = 2'd2
    } scan_st_t;

    localparam logic [2:0] SYSDIV_SEL  = 3'd1;
    localparam logic [2:0] POSTDIV_SEL = 3'd0;
    localparam logic       BYPASS_SEL  = 1'b0;
    localparam logic       HALVE_SEL   = 1'b0;

    function automatic logic [31:0] div_q(input logic [31:0] n, input logic [15:0] d);
        logic [16:0] r;
        logic [31:0] q;
        r = '0;
        q = '0;
        for (int i = 31; i >= 0; i--) begin
            r = {r[15:0], n[i]};
            if (r >= {1'b0, d}) begin
                r    = r - {1'b0, d};
                q[i] = 1'b1;
            end
        end
        return q;
    endfunction

    function automatic logic [15:0] div_r(input logic [31:0] n, input logic [15:0] d);
        logic [16:0] r;
        r = '0;
        for (int i = 31; i >= 0; i--) begin
            r = {r[15:0], n[i]};
            if (r >= {1'b0, d}) r = r - {1'b0, d};
        end
        return r[15:0];
    endfunction

endpackage

// File: rtl/fpll_search.sv
module fpll_search
    import fpll_pkg::*;
#(
    parameter int REF_MHZ  = 12,
    parameter int DM_MAX   = 8,
    parameter int DN_LIMIT = 256,
    parameter int FREQ_W   = 11,
    parameter int DM_W     = 4,
    parameter int DN_W     = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    input  logic [FREQ_W-1:0] freq_i,
    output logic              busy_o,
    output logic              res_valid_o,
    output logic [DM_W-1:0]   res_dm_o,
    output logic [DN_W-1:0]   res_dn_o
);

    localparam int X_W     = FREQ_W + DM_W;
    localparam int X_LIMIT = DN_LIMIT * REF_MHZ;
    localparam int REM_W   = $clog2(REF_MHZ + 1);

    scan_st_t          st_q;
    logic [FREQ_W-1:0] f_q;
    logic [X_W-1:0]    x_q;
    logic [DM_W-1:0]   try_q;
    logic [REM_W-1:0]  best_r_q;
    logic [DM_W-1:0]   best_dm_q;

    logic [REM_W-1:0]  rem_w;
    logic              over_w;
    logic              keep_w;
    logic              stop_w;
    logic [31:0]       prod_w;
    logic [DN_W-1:0]   dn_w;

    always_comb begin
        rem_w  = REM_W'(div_r(32'(x_q), 16'(REF_MHZ)));
        over_w = (32'(x_q) > 32'(X_LIMIT));
        keep_w = (rem_w <= best_r_q);
        stop_w = (rem_w == '0) || (try_q == DM_W'(DM_MAX));
        prod_w = 32'(f_q) * 32'(best_dm_q);
        dn_w   = DN_W'(div_q(prod_w, 16'(REF_MHZ)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= S_IDLE;
            f_q         <= '0;
            x_q         <= '0;
            try_q       <= '0;
            best_r_q    <= '0;
            best_dm_q   <= '0;
            res_valid_o <= 1'b0;
            res_dm_o    <= '0;
            res_dn_o    <= '0;
        end else begin
            res_valid_o <= 1'b0;
            unique case (st_q)
                S_IDLE: begin
                    if (go_i) begin
                        f_q       <= freq_i;
                        x_q       <= X_W'(freq_i);
                        try_q     <= DM_W'(1);
                        best_r_q  <= REM_W'(REF_MHZ);
                        best_dm_q <= DM_W'(1);
                        st_q      <= S_SCAN;
                    end
                end
                S_SCAN: begin
                    if (over_w) begin
                        st_q <= S_MUL;
                    end else begin
                        if (keep_w) begin
                            best_r_q  <= rem_w;
                            best_dm_q <= try_q;
                        end
                        if (stop_w) begin
                            st_q <= S_MUL;
                        end else begin
                            try_q <= try_q + DM_W'(1);
                            x_q   <= x_q + X_W'(f_q);
                        end
                    end
                end
                S_MUL: begin
                    res_dm_o    <= best_dm_q;
                    res_dn_o    <= dn_w;
                    res_valid_o <= 1'b1;
                    st_q        <= S_IDLE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign busy_o = (st_q != S_IDLE);

    // R3: the chosen divider lies in the searched range
    p_dm_legal_r3: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> (res_dm_o >= DM_W'(1) && res_dm_o <= DM_W'(DM_MAX)));

    // R4: the feedback count never exceeds its limit
    p_dn_cap_r4: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> (32'(res_dn_o) <= 32'(DN_LIMIT) && res_dn_o != '0));

    // R3: the best remainder never rises during a search
    p_rem_mono_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_SCAN && $past(st_q) == S_SCAN) |-> (best_r_q <= $past(best_r_q)));

endmodule

// File: rtl/fpll_pack.sv
module fpll_pack
    import fpll_pkg::*;
#(
    parameter int REF_MHZ    = 12,
    parameter int F_MIN      = 800,
    parameter int RANGE_STEP = 300,
    parameter int DM_W       = 4,
    parameter int DN_W       = 9
) (
    input  logic [DM_W-1:0] dm_i,
    input  logic [DN_W-1:0] dn_i,
    output pll_word_t       word_o
);

    logic [31:0] ach_w;
    logic [31:0] band_q_w;
    logic [1:0]  band_w;

    always_comb begin
        ach_w = div_q(32'(dn_i) * 32'(REF_MHZ), 16'(dm_i));
        if (ach_w < 32'(F_MIN)) begin
            band_q_w = '0;
        end else begin
            band_q_w = div_q(ach_w - 32'(F_MIN), 16'(RANGE_STEP));
        end
        band_w = (band_q_w > 32'd3) ? 2'd3 : 2'(band_q_w);

        word_o         = '0;
        word_o.fbdn    = 8'(dn_i - DN_W'(1));
        word_o.predm   = 4'(dm_i - DM_W'(1));
        word_o.postdiv = POSTDIV_SEL;
        word_o.band    = band_w;
        word_o.bypass  = BYPASS_SEL;
        word_o.halve   = HALVE_SEL;
        word_o.sysdiv  = SYSDIV_SEL;
    end

endmodule

// File: rtl/fpll_encoder.sv
module fpll_encoder
    import fpll_pkg::*;
#(
    parameter int REF_MHZ    = 12,
    parameter int DM_MAX     = 8,
    parameter int DN_LIMIT   = 256,
    parameter int FREQ_W     = 11,
    parameter int F_MIN      = 800,
    parameter int F_MAX      = 1999,
    parameter int RANGE_STEP = 300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] freq_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [31:0]       cfg_o
);

    localparam int DM_W  = $clog2(DM_MAX + 1);
    localparam int DN_W  = $clog2(DN_LIMIT + 1);
    localparam int LAT_W = $clog2(DM_MAX + 4) + 1;

    logic            in_range_w;
    logic            accept_w;
    logic            reject_w;
    logic            s_busy;
    logic            s_valid;
    logic [DM_W-1:0] s_dm;
    logic [DN_W-1:0] s_dn;
    pll_word_t       word_w;
    logic [LAT_W-1:0] lat_q;

    assign in_range_w = (32'(freq_i) >= 32'(F_MIN)) && (32'(freq_i) <= 32'(F_MAX));
    assign busy_o     = s_busy || s_valid;
    assign accept_w   = start_i && !busy_o && in_range_w;
    assign reject_w   = start_i && !busy_o && !in_range_w;

    fpll_search #(
        .REF_MHZ (REF_MHZ),
        .DM_MAX  (DM_MAX),
        .DN_LIMIT(DN_LIMIT),
        .FREQ_W  (FREQ_W),
        .DM_W    (DM_W),
        .DN_W    (DN_W)
    ) search_i (
        .clk        (clk),
        .rst        (rst),
        .go_i       (accept_w),
        .freq_i     (freq_i),
        .busy_o     (s_busy),
        .res_valid_o(s_valid),
        .res_dm_o   (s_dm),
        .res_dn_o   (s_dn)
    );

    fpll_pack #(
        .REF_MHZ   (REF_MHZ),
        .F_MIN     (F_MIN),
        .RANGE_STEP(RANGE_STEP),
        .DM_W      (DM_W),
        .DN_W      (DN_W)
    ) pack_i (
        .dm_i  (s_dm),
        .dn_i  (s_dn),
        .word_o(word_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            cfg_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (reject_w) begin
                done_o <= 1'b1;
                err_o  <= 1'b1;
            end
            if (accept_w) err_o <= 1'b0;
            if (s_valid) begin
                cfg_o  <= word_w;
                done_o <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         lat_q <= '0;
        else if (busy_o) lat_q <= lat_q + LAT_W'(1);
        else             lat_q <= '0;
    end

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7: a conversion never stays busy beyond its bound
    p_lat_bound_r7: assert property (@(posedge clk) disable iff (rst)
        32'(lat_q) <= 32'(DM_MAX + 2));

    // R2: a refusal leaves the configuration word untouched
    p_reject_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> $stable(cfg_o));

    // R6: every completed word carries the fixed constants
    p_fixed_fields_r6: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o) |-> (cfg_o[31:24] == 8'h00 && cfg_o[23:21] == 3'd1
                                && cfg_o[20:18] == 3'd0 && cfg_o[15:12] == 4'd0));

    // R8: a start while busy does not end the running conversion early
    p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
        (s_busy && start_i) |=> !done_o || s_valid == 1'b0);

endmodule

// File: tb/fpll_encoder_tb.sv
module fpll_encoder_tb_top;

    logic        clk;
    logic        rst;
    logic        start_i;
    logic [10:0] freq_i;
    logic        busy_o;
    logic        done_o;
    logic        err_o;
    logic [31:0] cfg_o;

    int total = 0;
    int bad   = 0;
    logic [31:0] last_good = 32'h0;

    typedef struct {
        logic [31:0] word;
        logic        err;
        int          freq;
    } exp_t;
    exp_t exp_q[$];

    fpll_encoder dut_i (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .freq_i (freq_i),
        .busy_o (busy_o),
        .done_o (done_o),
        .err_o  (err_o),
        .cfg_o  (cfg_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [31:0] model_word(input int f);
        int best_r, dm, dn, ach, band;
        best_r = 12;
        dm = 1;
        for (int t = 1; t <= 8; t++) begin
            int x, r;
            x = f * t;
            if (x > 3072) break;
            r = x % 12;
            if (r <= best_r) begin
                best_r = r;
                dm = t;
            end
            if (r == 0) break;
        end
        dn = (f * dm) / 12;
        ach = (dn * 12) / dm;
        band = (ach < 800) ? 0 : (ach - 800) / 300;
        if (band > 3) band = 3;
        return (32'd1 << 21) | (32'(band) << 16) | (32'(dm - 1) << 8) | 32'(dn - 1);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // monitor: compares each completion with the oldest expected item
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R8 unexpected done", {31'd0, done_o}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cfg_o == e.word, e.err ? "R2 word kept" : "R3/R4/R5/R6 word", cfg_o, e.word);
                check(err_o == e.err, "R2/R9 err flag", {31'd0, err_o}, {31'd0, e.err});
            end
        end
    end

    // driver: one request, waits for its completion and checks timing
    task automatic send(input int f, input bit extra_start);
        exp_t e;
        int n;
        bit ok_range;
        while (busy_o) @(negedge clk);
        ok_range = (f >= 800 && f <= 1999);
        e.freq = f;
        e.err  = !ok_range;
        e.word = ok_range ? model_word(f) : last_good;
        if (ok_range) last_good = e.word;
        exp_q.push_back(e);
        start_i = 1'b1;
        freq_i  = 11'(f);
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        if (ok_range) begin
            check(busy_o == 1'b1, "R7 busy after start", {31'd0, busy_o}, 32'd1);
            if (extra_start) begin
                // R8: a different request while busy must be dropped
                start_i = 1'b1;
                freq_i  = 11'd1500;
                @(negedge clk);
                start_i = 1'b0;
                n++;
            end
        end
        while (!done_o && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(done_o == 1'b1 && n <= 10, "R7 latency", 32'(n), 32'd10);
        check(busy_o == 1'b0, "R7 idle at done", {31'd0, busy_o}, 32'd0);
        @(negedge clk);
        check(done_o == 1'b0, "R7 single pulse", {31'd0, done_o}, 32'd0);
        if (!ok_range) begin
            check(err_o == 1'b1, "R9 err held", {31'd0, err_o}, 32'd1);
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog timeout actual=%0d expected=done", total);
        finish_run();
    end

    initial begin
        rst = 1'b1;
        start_i = 1'b0;
        freq_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset values
        check(done_o == 0 && err_o == 0 && busy_o == 0, "R1 flags", {29'd0, done_o, err_o, busy_o}, 32'd0);
        check(cfg_o == 32'h0, "R1 word", cfg_o, 32'h0);

        send(800, 0);      // R2 lower bound, R3 exact hit at dm=3
        send(801, 0);      // R3 tie-free descent to dm=3
        send(805, 0);      // R3 overflow stop keeps dm=1
        send(900, 0);      // R4 R5
        send(1000, 0);
        send(1024, 0);     // R3 x reaches 3072 exactly at dm=3
        send(1199, 0);
        send(799, 0);      // R2 below range
        send(1234, 0);     // R9 err cleared
        send(1500, 0);     // R5 band 2
        send(1999, 0);     // R2 upper bound, R5 band 3
        send(2000, 0);     // R2 above range
        send(0, 0);        // R2 zero
        send(1777, 1);     // R8 start while busy ignored
        send(1100, 0);     // R9
        send(1399, 1);     // R8
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R7/R8 all results seen", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule